// File: doc/BRIEF.md
# Multiplexed Address and Status Bus Driver

This block drives the shared address/status lines of a 16-bit processor bus cycle that runs through four states, T1 to T4. In T1 it puts the whole address on the lines so that an external latch can capture it. In T2, T3 and T4 it replaces the four most significant lines with bus-cycle status: the segment register used, the interrupt-enable flag and a constant zero. The pin that carries the active-low high-byte enable in T1 carries a spare status bit in the later states.

The block also steers the write data onto the correct half of the 16-bit data bus. The choice depends on the transfer width and on the address parity. IO cycles use the same address format as memory cycles, except that the top four address lines are forced to zero. Every output is registered, so each output shows the inputs sampled at the previous rising clock edge.

Top module: `mux_bus_drv`

## Requirements
- R1: While `rst_n` is low, `ads_o` is all zeros, `bhe_s7_n` is 1 and `data_o` is all zeros.
- R2: Outputs are registered. The values seen after a rising edge are a function of the inputs sampled at that edge.
- R3: In T1 (`tstate` = 00) of a memory cycle (`io_cycle` = 0), `ads_o` equals the full 20-bit `addr`, including bit 0 as supplied.
- R4: In T1 of an IO cycle, `ads_o[19:16]` is 0 and `ads_o[15:0]` equals `addr[15:0]`. This holds for any port from 0 to 65535, including the 0 to 255 range.
- R5: In T2, T3 and T4 (`tstate` = 01, 10, 11), for memory and IO cycles alike, `ads_o[19]` is 0 and `ads_o[18]` equals `int_en`.
- R6: In T2 to T4, `ads_o[17:16]` equals `seg_sel`, with the codes 00 extra, 01 stack, 10 code or none, 11 data. `ads_o[15:0]` keeps `addr[15:0]`.
- R7: In T1, `bhe_s7_n` is 0 when `word_xfer` is 1 or `addr[0]` is 1, and 1 otherwise.
- R8: In T2 to T4, `bhe_s7_n` carries the spare status bit, equal to the parameter `SPARE_S7`.
- R9: For a word transfer (`word_xfer` = 1), `data_o` equals `wdata`.
- R10: For a byte transfer at an even address, `data_o[7:0]` equals `wdata[7:0]` and `data_o[15:8]` is 0.
- R11: For a byte transfer at an odd address, `data_o[15:8]` equals `wdata[7:0]` and `data_o[7:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tstate | input | 2 | Bus state: 00 T1, 01 T2, 10 T3, 11 T4 |
| io_cycle | input | 1 | 1 for an IO cycle, 0 for a memory cycle |
| word_xfer | input | 1 | 1 for a 16-bit transfer, 0 for a byte transfer |
| addr | input | 20 | Memory address or IO port address |
| seg_sel | input | 2 | Segment register code used for the address |
| int_en | input | 1 | Current interrupt-enable flag |
| wdata | input | 16 | Write data; a byte transfer uses bits 7:0 |
| ads_o | output | 20 | Multiplexed address/status lines |
| bhe_s7_n | output | 1 | High-byte enable (active low) in T1, spare status bit otherwise |
| data_o | output | 16 | Steered data lanes |

## Verification
The bench builds two copies of the driver with the default 20-bit address and 16-bit data widths. The copies differ only in `SPARE_S7`, which is 0 in one and 1 in the other. With both values present, the spare-bit pin in T2 to T4 can be told apart from a stuck or T1-derived high-byte enable. The default widths put the exact 4/16 split of the address lines within reach, so forced-zero IO upper bits and status replacement are seen on real pin positions.

// File: rtl/mux_bus_drv.sv
module mux_bus_drv #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter bit SPARE_S7 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tstate,
  input  logic              io_cycle,
  input  logic              word_xfer,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        seg_sel,
  input  logic              int_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] ads_o,
  output logic              bhe_s7_n,
  output logic [DATA_W-1:0] data_o
);
  localparam int LO_W   = ADDR_W - 4;
  localparam int LANE_W = DATA_W / 2;

  logic       in_t1;
  logic [3:0] top_bits;
  logic       pin_bhe;
  logic [DATA_W-1:0] lanes;

  assign in_t1    = (tstate == 2'b00);
  assign top_bits = in_t1 ? (io_cycle ? 4'b0000 : addr[ADDR_W-1:LO_W])
                          : {1'b0, int_en, seg_sel};
  assign pin_bhe  = in_t1 ? ~(word_xfer | addr[0]) : SPARE_S7;

  always_comb begin
    if (word_xfer)
      lanes = wdata;
    else if (addr[0])
      lanes = {wdata[LANE_W-1:0], {LANE_W{1'b0}}};
    else
      lanes = {{LANE_W{1'b0}}, wdata[LANE_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ads_o    <= '0;
      bhe_s7_n <= 1'b1;
      data_o   <= '0;
    end else begin
      ads_o    <= {top_bits, addr[LO_W-1:0]};
      bhe_s7_n <= pin_bhe;
      data_o   <= lanes;
    end
  end

  AST_IO_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tstate == 2'b00) && $past(io_cycle) |-> ads_o[ADDR_W-1:LO_W] == 4'b0000); // R4
  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tstate != 2'b00) |-> !ads_o[ADDR_W-1] && ads_o[ADDR_W-2] == $past(int_en)); // R5
  AST_SEG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tstate != 2'b00) |-> ads_o[LO_W+1:LO_W] == $past(seg_sel)); // R6
  AST_WORD_BHE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tstate == 2'b00) && $past(word_xfer) |-> !bhe_s7_n); // R7
  AST_SPARE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(tstate != 2'b00) |-> bhe_s7_n == SPARE_S7); // R8
  AST_ODD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!word_xfer && addr[0]) |-> data_o[LANE_W-1:0] == '0); // R11
endmodule

// File: tb/mux_bus_drv_test.sv
module mux_bus_drv_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tstate = 2'b00;
  logic io_cycle = 1'b0, word_xfer = 1'b0, int_en = 1'b0;
  logic [19:0] addr = '0;
  logic [1:0] seg_sel = 2'b00;
  logic [15:0] wdata = '0;
  logic [19:0] ads_o, ads_b;
  logic bhe_s7_n, bhe_b;
  logic [15:0] data_o, data_b;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mux_bus_drv uut (.clk(clk), .rst_n(rst_n), .tstate(tstate), .io_cycle(io_cycle),
    .word_xfer(word_xfer), .addr(addr), .seg_sel(seg_sel), .int_en(int_en),
    .wdata(wdata), .ads_o(ads_o), .bhe_s7_n(bhe_s7_n), .data_o(data_o));
  mux_bus_drv #(.SPARE_S7(1'b1)) uut_s7 (.clk(clk), .rst_n(rst_n), .tstate(tstate),
    .io_cycle(io_cycle), .word_xfer(word_xfer), .addr(addr), .seg_sel(seg_sel),
    .int_en(int_en), .wdata(wdata), .ads_o(ads_b), .bhe_s7_n(bhe_b), .data_o(data_b));

  task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] ts, input logic io, input logic wd,
                       input logic [19:0] a, input logic [1:0] sg, input logic ie,
                       input logic [15:0] wd_v);
    @(negedge clk);
    tstate = ts; io_cycle = io; word_xfer = wd; addr = a;
    seg_sel = sg; int_en = ie; wdata = wd_v;
    @(negedge clk);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    drive(2'b00, 1'b0, 1'b1, 20'hFFFFF, 2'b11, 1'b1, 16'hFFFF);
    check("R1 ads", ads_o, 20'h0);
    check("R1 bhe", {19'b0, bhe_s7_n}, 20'h1);
    check("R1 data", {4'b0, data_o}, 20'h0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_t1_paths();
    drive(2'b00, 1'b0, 1'b0, 20'hF1235, 2'b10, 1'b0, 16'h00AB);
    check("R2 R3 mem odd byte ads", ads_o, 20'hF1235);
    check("R7 odd byte bhe", {19'b0, bhe_s7_n}, 20'h0);
    check("R11 odd lane", {4'b0, data_o}, 20'h0AB00);
    drive(2'b00, 1'b1, 1'b0, 20'h9_00FE, 2'b00, 1'b1, 16'h1234);
    check("R4 io direct port ads", ads_o, 20'h000FE);
    check("R7 even byte bhe", {19'b0, bhe_s7_n}, 20'h1);
    check("R10 even lane", {4'b0, data_o}, 20'h00034);
    drive(2'b00, 1'b1, 1'b1, 20'hA_FFFE, 2'b01, 1'b0, 16'hBEEF);
    check("R4 io full port ads", ads_o, 20'h0FFFE);
    check("R9 word data", {4'b0, data_o}, 20'h0BEEF);
  endtask

  task automatic test_sweep();
    for (int ts = 0; ts < 4; ts++)
      for (int sg = 0; sg < 4; sg++)
        for (int k = 0; k < 16; k++) begin
          logic io, wd, ie, od;
          logic [19:0] a, ea;
          logic [15:0] v, ed;
          logic eb;
          io = k[0]; wd = k[1]; ie = k[2]; od = k[3];
          a = 20'h7C3A4 ^ {ts[1:0], sg[1:0], 12'h5A0, k[3:0]};
          a[0] = od;
          v = 16'h9E61 + 16'(k * 37 + sg);
          drive(2'(ts), io, wd, a, 2'(sg), ie, v);
          if (ts == 0) ea = io ? {4'h0, a[15:0]} : a;
          else ea = {1'b0, ie, 2'(sg), a[15:0]};
          if (ts == 0) eb = ~(wd | od); else eb = 1'b0;
          if (wd) ed = v; else if (od) ed = {v[7:0], 8'h00}; else ed = {8'h00, v[7:0]};
          check(ts == 0 ? (io ? "R4 sweep ads" : "R3 sweep ads") : "R5 R6 sweep ads", ads_o, ea);
          check(ts == 0 ? "R7 sweep bhe" : "R8 sweep spare", {19'b0, bhe_s7_n}, {19'b0, eb});
          check("R9 R10 R11 sweep data", {4'b0, data_o}, {4'b0, ed});
          if (ts != 0) check("R8 spare one", {19'b0, bhe_b}, 20'h1);
          else check("R7 copy bhe", {19'b0, bhe_b}, {19'b0, eb});
        end
  endtask

  initial begin
    test_reset();
    test_t1_paths();
    test_sweep();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule